// File: doc/BRIEF.md
# Partitioned Performance Event Counter Bank

This block holds a set of event counters and one free-running cycle counter for a processor's performance monitoring unit. A boundary value, written by the hypervisor, divides the event counters into two ranges. Counters below the boundary belong to the guest. Counters at or above it are kept for the hypervisor. Each event counter steps once for every event pulse it receives while it is allowed to count. The cycle counter steps once per clock.

The upper range has its own controls. A master enable turns the whole range on or off. A freeze bit stops the range once any of its counters has overflowed. A long-mode bit moves the overflow point from the low half of a counter to its full width. A prohibit bit stops the range while the core runs at the hypervisor privilege level. Counters in the lower range ignore all four of these controls. The cycle counter has its own rules for when it is stopped at the hypervisor level. Overflow flags are sticky until a clear strobe arrives. The block's outputs are the counter values and the flags; the register interface around them lives elsewhere.

Top module: `pmu_counter_bank`

## Requirements
- R1: After reset, every event counter, the cycle counter and every overflow flag read zero.
- R2: With effective boundary E, counter i is in the upper range when i >= E. A boundary above NUM_CTR is treated as NUM_CTR, so every counter is in the lower range. A boundary of 0 puts every counter in the upper range when ZERO_BOUND_OK is 1, and is treated as NUM_CTR when it is 0.
- R3: A lower-range counter steps on an event pulse when its own enable bit is 1. An upper-range counter also needs `hyp_en` to be 1.
- R4: While `hyp_freeze` is 1 and any upper-range overflow flag is set, no upper-range counter steps. Lower-range counters and the cycle counter are not affected.
- R5: A lower-range counter raises its flag when its low CTR_W/2 bits wrap from all ones to zero. An upper-range counter does the same when `hyp_long` is 0, and raises its flag only on a wrap of all CTR_W bits when `hyp_long` is 1.
- R6: While `hyp_prohibit` and `at_hyp` are both 1, upper-range counters do not step. At the same time the cycle counter is held only if `cyc_prohibit_dp` is also 1.
- R7: While `cyc_hyp_dis` and `at_hyp` are both 1, the cycle counter holds its value. Event counters are not affected.
- R8: Overflow flags are sticky and clear through bit i of `ovf_clr`. A new overflow in the same cycle as the clear leaves the flag set.
- R9: A `ctr_clr` bit zeroes its counter on the next edge, even if an increment arrives in the same cycle. Counters wrap modulo 2^CTR_W.
- R10: The cycle counter steps every cycle while `cyc_en` is 1, unless R6 or R7 holds it. `cyc_clr` zeroes it. It ignores `hyp_en` and `hyp_freeze`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_pulse | input | NUM_CTR | One event per cycle per counter |
| ctr_en | input | NUM_CTR | Per-counter enable |
| cyc_en | input | 1 | Cycle counter enable |
| at_hyp | input | 1 | Core is at the hypervisor privilege level |
| bound | input | BW | Range boundary written by the hypervisor |
| hyp_en | input | 1 | Upper-range master enable |
| hyp_freeze | input | 1 | Upper-range freeze on overflow |
| hyp_long | input | 1 | Upper-range full-width overflow |
| hyp_prohibit | input | 1 | Upper-range stop at the hypervisor level |
| cyc_prohibit_dp | input | 1 | Lets `hyp_prohibit` also stop the cycle counter |
| cyc_hyp_dis | input | 1 | Cycle counter stop at the hypervisor level |
| ctr_clr | input | NUM_CTR | Per-counter zeroing strobe |
| cyc_clr | input | 1 | Cycle counter zeroing strobe |
| ovf_clr | input | NUM_CTR | Write-one-to-clear overflow strobe |
| ctr_val | output | NUM_CTR*CTR_W | Counter values, counter i at bits [i*CTR_W +: CTR_W] |
| cyc_val | output | CTR_W | Cycle counter value |
| ovf | output | NUM_CTR | Sticky overflow flags |

## Verification
The hardest cases to reach are the ones where a control depends on an overflow that has already happened. The freeze lock-out needs an upper-range flag to be set. A full-width wrap in long mode needs 2^CTR_W increments, which cannot be done at the default width. The bench therefore uses a 12-bit counter, so the low half wraps after 64 events and the full width after 4096. It drives pulses on every cycle with clears switched off, so both kinds of wrap happen within a few thousand cycles. In the freeze phase, flag clears are rare, so the range stays frozen for long stretches and then restarts after a clear. A behavioural model compares every counter and flag against the design on every clock.

// File: rtl/pmu_counter_bank.sv
module pmu_counter_bank #(
  parameter int NUM_CTR       = 4,
  parameter int CTR_W         = 64,
  parameter int ZERO_BOUND_OK = 1,
  localparam int BW           = $clog2(NUM_CTR + 1)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_CTR-1:0]         evt_pulse,
  input  logic [NUM_CTR-1:0]         ctr_en,
  input  logic                       cyc_en,
  input  logic                       at_hyp,
  input  logic [BW-1:0]              bound,
  input  logic                       hyp_en,
  input  logic                       hyp_freeze,
  input  logic                       hyp_long,
  input  logic                       hyp_prohibit,
  input  logic                       cyc_prohibit_dp,
  input  logic                       cyc_hyp_dis,
  input  logic [NUM_CTR-1:0]         ctr_clr,
  input  logic                       cyc_clr,
  input  logic [NUM_CTR-1:0]         ovf_clr,
  output logic [NUM_CTR*CTR_W-1:0]   ctr_val,
  output logic [CTR_W-1:0]           cyc_val,
  output logic [NUM_CTR-1:0]         ovf
);
  localparam int HALF = CTR_W / 2;

  logic [BW-1:0]      eff_b;
  logic [NUM_CTR-1:0] upper, inc, wrap;
  logic               hi_ovf, hi_gate, cyc_run;
  logic [CTR_W-1:0]   cnt [NUM_CTR];

  assign eff_b = (bound > BW'(NUM_CTR)) ? BW'(NUM_CTR) :
                 (bound == '0 && ZERO_BOUND_OK == 0) ? BW'(NUM_CTR) : bound;
  assign hi_ovf  = |(ovf & upper);
  assign hi_gate = hyp_en & ~(hyp_freeze & hi_ovf) & ~(hyp_prohibit & at_hyp);
  assign cyc_run = cyc_en & ~(at_hyp & cyc_hyp_dis) & ~(at_hyp & hyp_prohibit & cyc_prohibit_dp);

  for (genvar i = 0; i < NUM_CTR; i++) begin : g_ctr
    assign upper[i] = BW'(i) >= eff_b;
    assign inc[i]   = evt_pulse[i] & ctr_en[i] & (~upper[i] | hi_gate);
    assign wrap[i]  = inc[i] & ~ctr_clr[i] &
                      ((upper[i] & hyp_long) ? (&cnt[i]) : (&cnt[i][HALF-1:0]));
    assign ctr_val[i*CTR_W +: CTR_W] = cnt[i];

    always_ff @(posedge clk) begin
      if (!rst_n)          cnt[i] <= '0;
      else if (ctr_clr[i]) cnt[i] <= '0;
      else if (inc[i])     cnt[i] <= cnt[i] + 1'b1;
    end

    always_ff @(posedge clk) begin
      if (!rst_n)          ovf[i] <= 1'b0;
      else if (wrap[i])    ovf[i] <= 1'b1;
      else if (ovf_clr[i]) ovf[i] <= 1'b0;
    end

    // R3
    hyp_en_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (upper[i] && !hyp_en && !ctr_clr[i]) |=> $stable(cnt[i]));
    // R4
    freeze_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (upper[i] && hyp_freeze && hi_ovf && !ctr_clr[i]) |=> $stable(cnt[i]));
    // R6
    prohibit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (upper[i] && hyp_prohibit && at_hyp && !ctr_clr[i]) |=> $stable(cnt[i]));
    // R9
    clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ctr_clr[i] |=> (cnt[i] == '0));
    // R8
    sticky_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf[i] && !ovf_clr[i]) |=> ovf[i]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       cyc_val <= '0;
    else if (cyc_clr) cyc_val <= '0;
    else if (cyc_run) cyc_val <= cyc_val + 1'b1;
  end

  // R7
  cyc_hyp_dis_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (at_hyp && cyc_hyp_dis && !cyc_clr) |=> $stable(cyc_val));
  // R10
  cyc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_en && !at_hyp && !cyc_clr) |=> (cyc_val == $past(cyc_val) + 1'b1));
endmodule

// File: tb/pmu_counter_bank_tb.sv
module pmu_counter_bank_tb;
  localparam int N  = 4;
  localparam int W  = 12;
  localparam int H  = W / 2;
  localparam int BW = $clog2(N + 1);

  logic clk = 1'b0, rst_n = 1'b0;
  logic [N-1:0] evt_pulse = '0, ctr_en = '0, ctr_clr = '0, ovf_clr = '0;
  logic cyc_en = 1'b0, at_hyp = 1'b0, hyp_en = 1'b0, hyp_freeze = 1'b0;
  logic hyp_long = 1'b0, hyp_prohibit = 1'b0, cyc_prohibit_dp = 1'b0;
  logic cyc_hyp_dis = 1'b0, cyc_clr = 1'b0;
  logic [BW-1:0] bound = BW'(N);
  logic [N*W-1:0] ctr_val;
  logic [W-1:0] cyc_val;
  logic [N-1:0] ovf;

  int checks = 0, fails = 0;
  string tag = "R1";
  bit done = 1'b0;

  always #4 clk = ~clk;

  pmu_counter_bank #(.NUM_CTR(N), .CTR_W(W), .ZERO_BOUND_OK(1)) u_dut (
    .clk(clk), .rst_n(rst_n), .evt_pulse(evt_pulse), .ctr_en(ctr_en),
    .cyc_en(cyc_en), .at_hyp(at_hyp), .bound(bound), .hyp_en(hyp_en),
    .hyp_freeze(hyp_freeze), .hyp_long(hyp_long), .hyp_prohibit(hyp_prohibit),
    .cyc_prohibit_dp(cyc_prohibit_dp), .cyc_hyp_dis(cyc_hyp_dis),
    .ctr_clr(ctr_clr), .cyc_clr(cyc_clr), .ovf_clr(ovf_clr),
    .ctr_val(ctr_val), .cyc_val(cyc_val), .ovf(ovf));

  longint m_cnt [N];
  longint m_cyc;
  bit     m_ovf [N];

  function automatic int eff_bound(int b);
    if (b > N) return N;
    return b;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) begin m_cnt[i] = 0; m_ovf[i] = 0; end
      m_cyc = 0;
    end else begin
      int  eb;
      bit  hi_any;
      longint lo_m, full_m;
      eb = eff_bound(int'(bound));
      lo_m = (64'd1 << H) - 1;
      full_m = (64'd1 << W) - 1;
      hi_any = 0;
      for (int i = 0; i < N; i++) if (i >= eb && m_ovf[i]) hi_any = 1;
      for (int i = 0; i < N; i++) begin
        bit up, go, wr;
        up = (i >= eb);
        go = evt_pulse[i] && ctr_en[i] &&
             (!up || (hyp_en && !(hyp_freeze && hi_any) && !(hyp_prohibit && at_hyp)));
        wr = go && !ctr_clr[i] &&
             ((up && hyp_long) ? (m_cnt[i] == full_m) : ((m_cnt[i] & lo_m) == lo_m));
        if (ctr_clr[i]) m_cnt[i] = 0;
        else if (go)    m_cnt[i] = (m_cnt[i] + 1) & full_m;
        if (wr) m_ovf[i] = 1;
        else if (ovf_clr[i]) m_ovf[i] = 0;
      end
      if (cyc_clr) m_cyc = 0;
      else if (cyc_en && !(at_hyp && cyc_hyp_dis) && !(at_hyp && hyp_prohibit && cyc_prohibit_dp))
        m_cyc = (m_cyc + 1) & ((64'd1 << W) - 1);
    end
  end

  task automatic compare();
    for (int i = 0; i < N; i++) begin
      checks++;
      if (longint'(ctr_val[i*W +: W]) != m_cnt[i]) begin
        fails++;
        $display("FAIL %s: counter %0d actual %0d expected %0d", tag, i, ctr_val[i*W +: W], m_cnt[i]);
      end
      checks++;
      if (ovf[i] != m_ovf[i]) begin
        fails++;
        $display("FAIL %s: flag %0d actual %0b expected %0b", tag, i, ovf[i], m_ovf[i]);
      end
    end
    checks++;
    if (longint'(cyc_val) != m_cyc) begin
      fails++;
      $display("FAIL %s: cycle counter actual %0d expected %0d", tag, cyc_val, m_cyc);
    end
  endtask

  task automatic run(string t, int cycles, int pulse_pct, int clr_div, int oclr_div);
    tag = t;
    for (int c = 0; c < cycles; c++) begin
      @(negedge clk);
      compare();
      for (int i = 0; i < N; i++) begin
        evt_pulse[i] = ($urandom_range(99) < pulse_pct);
        ctr_clr[i]   = (clr_div > 0) && ($urandom_range(clr_div - 1) == 0);
        ovf_clr[i]   = (oclr_div > 0) && ($urandom_range(oclr_div - 1) == 0);
      end
      cyc_clr = (clr_div > 0) && ($urandom_range(clr_div - 1) == 0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    tag = "R1";
    compare();
    rst_n = 1'b1;
    cyc_en = 1'b1;
    ctr_en = '1;
    // R2 / R3: boundary 2, upper range disabled by hyp_en
    bound = 3'd2; hyp_en = 0;
    run("R2", 300, 70, 128, 16);
    // R3: upper range enabled, mixed per-counter enables
    hyp_en = 1; ctr_en = 4'b1010;
    run("R3", 300, 70, 128, 16);
    ctr_en = '1;
    // R2: zero boundary puts all in upper range, hyp_en off
    bound = 3'd0; hyp_en = 0;
    run("R2", 300, 80, 128, 16);
    // R2: boundary above N clamps, all lower range
    bound = 3'd7;
    run("R2", 300, 80, 128, 16);
    // R5: low-half overflow, R8 sticky flags with rare clears
    bound = 3'd2; hyp_en = 1; hyp_long = 0;
    run("R5", 400, 100, 0, 50);
    // R5: long mode on all-upper range, full-width wrap
    bound = 3'd0; hyp_long = 1;
    ctr_clr = '1; @(negedge clk); compare(); ctr_clr = '0;
    run("R5", 4300, 100, 0, 0);
    // R4: freeze on upper overflow
    bound = 3'd2; hyp_long = 0; hyp_freeze = 1;
    run("R4", 1200, 100, 0, 60);
    hyp_freeze = 0;
    // R6: hypervisor prohibit, cycle counter held only with dp
    at_hyp = 1; hyp_prohibit = 1; cyc_prohibit_dp = 0;
    run("R6", 200, 70, 128, 16);
    cyc_prohibit_dp = 1;
    run("R6", 200, 70, 128, 16);
    // R7: cycle disable at hypervisor level
    hyp_prohibit = 0; cyc_prohibit_dp = 0; cyc_hyp_dis = 1;
    run("R7", 200, 70, 128, 16);
    at_hyp = 0;
    run("R7", 100, 70, 128, 16);
    // R9 / R8: frequent clears against increments and overflows
    cyc_hyp_dis = 0; bound = 3'd3;
    run("R9", 600, 100, 8, 4);
    // R10: cycle counter off, then on with freeze and hyp_en toggled
    cyc_en = 0;
    run("R10", 100, 50, 0, 16);
    cyc_en = 1; hyp_en = 0; hyp_freeze = 1;
    run("R10", 200, 50, 0, 16);
    @(negedge clk);
    compare();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule